// File: doc/BRIEF.md
# Projective-to-affine coordinate converter

This block takes the end state of a binary-field Montgomery-ladder scalar multiplication, the projective pairs (X1, Z1) and (X2, Z2), plus the affine base point (xP, yP). It returns the affine result (x3, y3) of the scalar product. Everything is computed in GF(2^M), with polynomial basis and a reduction polynomial given as a parameter. The field size is a parameter as well, so the same RTL can be checked in a small field.

A sequencer shares two digit-serial multipliers (10 operand bits per cycle by default) and one combinational squarer. It runs ten field multiplications and a single field inversion. The inversion uses an Itoh–Tsujii addition chain of repeated squarings and multiplications. The value inverted is xP·Z1·Z2, and 1/Z1 is then recovered from it with one extra product. The block sits on its own clock. A start pulse captures all six operands. After a fixed number of cycles a done flag rises, and the results are held until the next accepted start.

Top module: `p2a_convert`

## Requirements
- R1: When done rises with err low, x3 equals X1·Z1^-1 in GF(2^M). Field elements are M-bit vectors, bit i being the coefficient of x^i, reduced by the parameter polynomial.
- R2: When done rises with err low, y3 equals (xP + x3)·[(X1 + xP·Z1)(X2 + xP·Z2) + (xP^2 + yP)·Z1·Z2]·(xP·Z1·Z2)^-1 + yP.
- R3: The clock edge that samples start high in idle counts as edge 1. done is low after edge LAT-1 and high after edge LAT, where LAT = 15·ceil(M/DIGIT) + 214 and DIGIT defaults to 10.
- R4: If the captured Z1 is zero, done still rises after LAT edges, but with err high and x3 = y3 = 0. The next accepted start clears err.
- R5: The operands are captured on the accepted start edge. Changing the operand inputs afterwards does not alter the result.
- R6: A start pulse while a conversion is running is ignored. The running result is unchanged, and no second done follows.
- R7: From the rise of done until the next accepted start, done, err, x3 and y3 stay constant. The edge that accepts a new start lowers done.
- R8: After reset, done and err are low and x3 and y3 are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Converter clock, separate from the ladder clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a conversion when idle |
| x1_in | input | M | Ladder X1 |
| z1_in | input | M | Ladder Z1 |
| x2_in | input | M | Ladder X2 |
| z2_in | input | M | Ladder Z2 |
| xp_in | input | M | Base point x |
| yp_in | input | M | Base point y |
| done | output | 1 | Result valid, held until next start |
| err | output | 1 | Z1 was zero (point at infinity) |
| x3 | output | M | Affine x of the result |
| y3 | output | M | Affine y of the result |

## Verification
Most internal faults stay hidden until done. A wrong operand select, a lost squaring in the inversion chain, or a bad reduction tap gives a wrong x3 or y3 only after the full LAT cycles. The bench therefore compares every result with field arithmetic that inverts by Fermat exponentiation, not by the block's own chain. Faults in the sequencer's timing show up sooner and more sharply: done one edge early or late, or done dropping before the next start. Faults in operand capture appear as results that follow inputs changed in mid-run.

// File: rtl/p2a_pkg.sv
package p2a_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_R1,     // xP*Z1 , xP*Z2
    ST_R2,     // Z1*Z2 , (X1+xPZ1)(X2+xPZ2)
    ST_R3,     // xP*Z1Z2 , (xP^2+yP)*Z1Z2
    ST_IINIT,
    ST_ISQ,    // repeated squaring of doubling step
    ST_IMUL,   // doubling multiply
    ST_IASQ,   // single squaring of increment step
    ST_IAMUL,  // increment multiply by the base
    ST_IFIN,   // final squaring gives the inverse
    ST_R4,     // 1/Z1 , sum * inverse
    ST_R5,     // x3
    ST_R6,     // y3
    ST_PAD
  } p2a_state_e;

  // position of the highest set bit of a positive integer
  function automatic int p2a_msb(input int v);
    int r;
    r = 0;
    for (int i = 0; i < 31; i++) if ((v >> i) != 0) r = i;
    return r;
  endfunction

endpackage

// File: rtl/p2a_gf_mul.sv
module p2a_gf_mul #(
  parameter int       M    = 163,
  parameter int       D    = 10,
  parameter logic [M:0] POLY = {1'b1, {(M-8){1'b0}}, 8'hC9}
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         go,
  input  logic [M-1:0] op_a,
  input  logic [M-1:0] op_b,
  output logic         busy,
  output logic [M-1:0] prod
);
  localparam int N  = (M + D - 1) / D;
  localparam int BW = N * D;
  localparam int CW = $clog2(N + 1);

  logic [M-1:0]  a_q, acc_q;
  logic [BW-1:0] b_q;
  logic [CW-1:0] cnt_q;
  logic          busy_q;

  // reduce an (M+D)-bit polynomial modulo POLY
  function automatic logic [M-1:0] fold(input logic [M+D-1:0] v);
    logic [M+D-1:0] t;
    t = v;
    for (int i = M + D - 1; i >= M; i--)
      if (t[i]) t = t ^ ({{(D-1){1'b0}}, POLY} << (i - M));
    return t[M-1:0];
  endfunction

  // a times one D-bit digit, carry-less
  function automatic logic [M+D-1:0] digit_mul(input logic [M-1:0] a, input logic [D-1:0] d);
    logic [M+D-1:0] r;
    r = '0;
    for (int j = 0; j < D; j++)
      if (d[j]) r = r ^ ({{D{1'b0}}, a} << j);
    return r;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q    <= '0;
      b_q    <= '0;
      acc_q  <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
    end else if (go) begin
      a_q    <= op_a;
      b_q    <= BW'(op_b);
      acc_q  <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b1;
    end else if (busy_q) begin
      acc_q <= acc_q ^ fold(digit_mul(a_q, b_q[D-1:0]));
      a_q   <= fold({a_q, {D{1'b0}}});
      b_q   <= b_q >> D;
      cnt_q <= cnt_q + 1'b1;
      if (cnt_q == CW'(N - 1)) busy_q <= 1'b0;
    end
  end

  assign busy = busy_q;
  assign prod = acc_q;

  // a new product may only be launched on an idle multiplier (schedule timing, R3)
  assert_go_idle_R3: assert property (@(posedge clk) disable iff (!rst_n) go |-> !busy_q);
  assert_go_busy_R3: assert property (@(posedge clk) disable iff (!rst_n) go |=> busy_q);

endmodule

// File: rtl/p2a_gf_sq.sv
module p2a_gf_sq #(
  parameter int       M    = 163,
  parameter logic [M:0] POLY = {1'b1, {(M-8){1'b0}}, 8'hC9}
) (
  input  logic [M-1:0] a,
  output logic [M-1:0] y
);
  always_comb begin
    logic [2*M-1:0] t;
    t = '0;
    for (int i = 0; i < M; i++) t[2*i] = a[i];
    for (int i = 2 * M - 1; i >= M; i--)
      if (t[i]) t = t ^ ({{(M-1){1'b0}}, POLY} << (i - M));
    y = t[M-1:0];
  end
endmodule

// File: rtl/p2a_lat_timer.sv
module p2a_lat_timer #(
  parameter int LAT = 469,
  parameter int CW  = $clog2(LAT + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          launch,
  output logic          expire,
  output logic [CW-1:0] count
);
  logic          run_q;
  logic [CW-1:0] cnt_q;

  assign expire = run_q && (cnt_q == CW'(LAT - 1));
  assign count  = cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      cnt_q <= '0;
    end else if (launch) begin
      run_q <= 1'b1;
      cnt_q <= CW'(1);
    end else if (run_q) begin
      cnt_q <= cnt_q + 1'b1;
      if (expire) run_q <= 1'b0;
    end
  end

  assert_expire_once_R3: assert property (@(posedge clk) disable iff (!rst_n) expire |=> !expire);

endmodule

// File: rtl/p2a_convert.sv
module p2a_convert
  import p2a_pkg::*;
#(
  parameter int       M     = 163,
  parameter int       DIGIT = 10,
  parameter logic [M:0] POLY  = {1'b1, {(M-8){1'b0}}, 8'hC9}
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [M-1:0] x1_in,
  input  logic [M-1:0] z1_in,
  input  logic [M-1:0] x2_in,
  input  logic [M-1:0] z2_in,
  input  logic [M-1:0] xp_in,
  input  logic [M-1:0] yp_in,
  output logic         done,
  output logic         err,
  output logic [M-1:0] x3,
  output logic [M-1:0] y3
);
  localparam int NDIG = (M + DIGIT - 1) / DIGIT;
  localparam int LAT  = 15 * NDIG + 214;
  localparam int TCW  = $clog2(LAT + 1);
  localparam int TOP  = p2a_msb(M - 1);      // chain length for exponent M-1
  localparam int KW   = $clog2(M + 1);
  localparam int IW   = $clog2(M) + 1;
  localparam logic [31:0] NM1 = 32'(M - 1);

  p2a_state_e state;

  logic [M-1:0] x1_q, z1_q, x2_q, z2_q, xp_q, yp_q;
  logic [M-1:0] ra_q, rb_q, rc_q, rd_q, re_q, rf_q, xsq_q;
  logic [M-1:0] beta_q, tmp_q;
  logic [KW-1:0] k_q, sqc_q;
  logic [IW-1:0] idx_q;
  logic          issued_q, errp_q;
  logic          done_q, err_q;
  logic [M-1:0]  x3_q, y3_q;

  // named internal events
  logic          accept, adv, work_end, go0, go1, expire;
  logic [TCW-1:0] tmr_cnt;
  logic          busy0, busy1;
  logic [M-1:0]  ma0, mb0, ma1, mb1, p0, p1, sq_in, sq_out;

  assign accept   = (state == ST_IDLE) && start;
  assign go0      = !issued_q && (state inside {ST_R1, ST_R2, ST_R3, ST_IMUL, ST_IAMUL,
                                                ST_R4, ST_R5, ST_R6});
  assign go1      = !issued_q && (state inside {ST_R1, ST_R2, ST_R3, ST_R4});
  assign adv      = issued_q && !busy0 && !busy1;
  assign work_end = (state == ST_R6) && adv;

  // operand routing for the two multipliers
  always_comb begin
    ma0 = '0; mb0 = '0; ma1 = '0; mb1 = '0;
    case (state)
      ST_R1:    begin ma0 = xp_q;  mb0 = z1_q;   ma1 = xp_q;          mb1 = z2_q;  end
      ST_R2:    begin ma0 = z1_q;  mb0 = z2_q;   ma1 = x1_q ^ ra_q;   mb1 = x2_q ^ rb_q; end
      ST_R3:    begin ma0 = xp_q;  mb0 = rc_q;   ma1 = xsq_q ^ yp_q;  mb1 = rc_q;  end
      ST_IMUL:  begin ma0 = tmp_q; mb0 = beta_q; end
      ST_IAMUL: begin ma0 = tmp_q; mb0 = rd_q;   end
      ST_R4:    begin ma0 = tmp_q; mb0 = rb_q;   ma1 = re_q ^ rf_q;   mb1 = tmp_q; end
      ST_R5:    begin ma0 = x1_q;  mb0 = ra_q;   end
      ST_R6:    begin ma0 = re_q ^ xp_q; mb0 = rf_q; end
      default:  ;
    endcase
  end

  always_comb begin
    case (state)
      ST_ISQ:  sq_in = tmp_q;
      ST_IASQ: sq_in = beta_q;
      ST_IFIN: sq_in = beta_q;
      default: sq_in = xp_q;
    endcase
  end

  p2a_gf_mul #(.M(M), .D(DIGIT), .POLY(POLY)) u_mul0 (
    .clk(clk), .rst_n(rst_n), .go(go0), .op_a(ma0), .op_b(mb0), .busy(busy0), .prod(p0));
  p2a_gf_mul #(.M(M), .D(DIGIT), .POLY(POLY)) u_mul1 (
    .clk(clk), .rst_n(rst_n), .go(go1), .op_a(ma1), .op_b(mb1), .busy(busy1), .prod(p1));
  p2a_gf_sq #(.M(M), .POLY(POLY)) u_sq (.a(sq_in), .y(sq_out));
  p2a_lat_timer #(.LAT(LAT), .CW(TCW)) u_tmr (
    .clk(clk), .rst_n(rst_n), .launch(accept), .expire(expire), .count(tmr_cnt));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      {x1_q, z1_q, x2_q, z2_q, xp_q, yp_q} <= '0;
      {ra_q, rb_q, rc_q, rd_q, re_q, rf_q, xsq_q} <= '0;
      beta_q <= '0; tmp_q <= '0;
      k_q <= '0; sqc_q <= '0; idx_q <= '0;
      issued_q <= 1'b0; errp_q <= 1'b0;
      done_q <= 1'b0; err_q <= 1'b0;
      x3_q <= '0; y3_q <= '0;
    end else begin
      if (go0) issued_q <= 1'b1;
      else if (adv) issued_q <= 1'b0;

      case (state)
        ST_IDLE: if (start) begin
          x1_q <= x1_in; z1_q <= z1_in; x2_q <= x2_in;
          z2_q <= z2_in; xp_q <= xp_in; yp_q <= yp_in;
          done_q <= 1'b0;
          err_q  <= 1'b0;
          errp_q <= (z1_in == '0);
          state  <= (z1_in == '0) ? ST_PAD : ST_R1;
        end
        ST_R1: if (adv) begin
          ra_q <= p0; rb_q <= p1; xsq_q <= sq_out; state <= ST_R2;
        end
        ST_R2: if (adv) begin
          rc_q <= p0; re_q <= p1; state <= ST_R3;
        end
        ST_R3: if (adv) begin
          rd_q <= p0; rf_q <= p1; state <= ST_IINIT;
        end
        ST_IINIT: begin
          beta_q <= rd_q;
          tmp_q  <= rd_q;
          k_q    <= KW'(1);
          sqc_q  <= KW'(1);
          idx_q  <= IW'(TOP - 1);
          state  <= (TOP == 0) ? ST_IFIN : ST_ISQ;
        end
        ST_ISQ: begin
          tmp_q <= sq_out;
          sqc_q <= sqc_q - 1'b1;
          if (sqc_q == KW'(1)) state <= ST_IMUL;
        end
        ST_IMUL: if (adv) begin
          beta_q <= p0;
          k_q    <= k_q << 1;
          if (NM1[idx_q]) state <= ST_IASQ;
          else if (idx_q == '0) state <= ST_IFIN;
          else begin
            idx_q <= idx_q - 1'b1;
            tmp_q <= p0;
            sqc_q <= k_q << 1;
            state <= ST_ISQ;
          end
        end
        ST_IASQ: begin
          tmp_q <= sq_out;
          state <= ST_IAMUL;
        end
        ST_IAMUL: if (adv) begin
          beta_q <= p0;
          k_q    <= k_q + 1'b1;
          if (idx_q == '0) state <= ST_IFIN;
          else begin
            idx_q <= idx_q - 1'b1;
            tmp_q <= p0;
            sqc_q <= k_q + 1'b1;
            state <= ST_ISQ;
          end
        end
        ST_IFIN: begin
          tmp_q <= sq_out;             // (xP Z1 Z2)^-1
          state <= ST_R4;
        end
        ST_R4: if (adv) begin
          ra_q <= p0;                  // 1/Z1
          rf_q <= p1;                  // bracket sum times inverse
          state <= ST_R5;
        end
        ST_R5: if (adv) begin
          re_q <= p0;                  // x3
          state <= ST_R6;
        end
        ST_R6: if (adv) begin
          rc_q <= p0 ^ yp_q;           // y3
          state <= ST_PAD;
        end
        ST_PAD: if (expire) begin
          x3_q   <= errp_q ? '0 : re_q;
          y3_q   <= errp_q ? '0 : rc_q;
          err_q  <= errp_q;
          done_q <= 1'b1;
          state  <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign done = done_q;
  assign err  = err_q;
  assign x3   = x3_q;
  assign y3   = y3_q;

  // the schedule must finish before the fixed latency runs out
  assert_work_fits_R3: assert property (@(posedge clk) disable iff (!rst_n)
    work_end |-> (tmr_cnt <= TCW'(LAT - 2)));
  // captured operands cannot move while a conversion runs
  assert_capture_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (state != ST_IDLE) |=> ($stable(z1_q) && $stable(x1_q) && $stable(xp_q) && $stable(yp_q)));
  // error result carries no coordinates
  assert_err_no_coord_R4: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |-> (x3_q == '0 && y3_q == '0));
  assert_err_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_q) |-> (z1_q == '0));
  // results hold from done until a new start is accepted
  assert_done_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && !start) |=> (done_q && $stable(x3_q) && $stable(y3_q) && $stable(err_q)));
  // a start during a run does not end or restart it
  assert_busy_start_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (state inside {ST_R2, ST_R3, ST_ISQ} && start) |=> (state != ST_IDLE && !done_q));

endmodule

// File: tb/p2a_convert_tb_top.sv
module p2a_convert_tb_top;
  localparam int M = 19;
  localparam logic [M:0] POLY = 20'h80027;   // x^19 + x^5 + x^2 + x + 1
  localparam int LAT = 15 * ((M + 9) / 10) + 214;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [M-1:0] x1_in = '0, z1_in = '0, x2_in = '0, z2_in = '0, xp_in = '0, yp_in = '0;
  logic done, err;
  logic [M-1:0] x3, y3;

  int n_chk = 0;
  int n_fail = 0;
  logic [31:0] seed = 32'h1234_5678;

  always #10 clk = ~clk;

  p2a_convert #(.M(M), .DIGIT(10), .POLY(POLY)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start),
    .x1_in(x1_in), .z1_in(z1_in), .x2_in(x2_in), .z2_in(z2_in),
    .xp_in(xp_in), .yp_in(yp_in),
    .done(done), .err(err), .x3(x3), .y3(y3));

  // reference field arithmetic: shift-and-add multiply, Fermat inverse
  function automatic logic [M-1:0] fmul(input logic [M-1:0] a, input logic [M-1:0] b);
    logic [M:0] r;
    r = '0;
    for (int i = M - 1; i >= 0; i--) begin
      r = r << 1;
      if (r[M]) r = r ^ POLY;
      if (b[i]) r = r ^ {1'b0, a};
    end
    return r[M-1:0];
  endfunction

  function automatic logic [M-1:0] finv(input logic [M-1:0] a);
    logic [M-1:0] r, s;
    r = {{(M-1){1'b0}}, 1'b1};
    s = a;
    for (int i = 1; i < M; i++) begin
      s = fmul(s, s);
      r = fmul(r, s);
    end
    return r;
  endfunction

  function automatic logic [M-1:0] nextval();
    seed = seed ^ (seed << 13);
    seed = seed ^ (seed >> 17);
    seed = seed ^ (seed << 5);
    return seed[M-1:0];
  endfunction

  task automatic chk(input bit ok, input string what, input logic [M-1:0] act, input logic [M-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", what, act, exp);
    end
  endtask

  task automatic drive_ops(input logic [M-1:0] a1, c1, a2, c2, ap, bp);
    x1_in = a1; z1_in = c1; x2_in = a2; z2_in = c2; xp_in = ap; yp_in = bp;
  endtask

  // one conversion; poke scrambles inputs and pulses start during the run
  task automatic t_convert(input logic [M-1:0] a1, c1, a2, c2, ap, bp, input bit poke);
    logic [M-1:0] ex3, ey3, s1, s2, zz, sm;
    ex3 = fmul(a1, finv(c1));
    s1  = a1 ^ fmul(ap, c1);
    s2  = a2 ^ fmul(ap, c2);
    zz  = fmul(c1, c2);
    sm  = fmul(s1, s2) ^ fmul(fmul(ap, ap) ^ bp, zz);
    ey3 = fmul(fmul(ap ^ ex3, sm), finv(fmul(ap, zz))) ^ bp;

    @(negedge clk);
    drive_ops(a1, c1, a2, c2, ap, bp);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(done == 1'b0, "R7 done low after accepted start", M'(done), '0);
    for (int i = 0; i < LAT - 2; i++) begin
      @(negedge clk);
      if (poke) begin
        if (i == 5) drive_ops(nextval(), nextval(), nextval(), nextval(), nextval(), nextval());
        start = (i == 20);
      end
    end
    start = 1'b0;
    chk(done == 1'b0, "R3 done low one edge before latency", M'(done), '0);
    @(negedge clk);
    chk(done == 1'b1, "R3 done high at latency", M'(done), M'(1));
    chk(err == 1'b0, "R4 err low for nonzero Z1", M'(err), '0);
    chk(x3 == ex3, poke ? "R1 R5 R6 x3 with inputs changed mid-run" : "R1 x3", x3, ex3);
    chk(y3 == ey3, poke ? "R2 R5 R6 y3 with inputs changed mid-run" : "R2 y3", y3, ey3);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(done == 1'b0, "R8 done after reset", M'(done), '0);
    chk(err == 1'b0, "R8 err after reset", M'(err), '0);
    chk(x3 == '0, "R8 x3 after reset", x3, '0);
    chk(y3 == '0, "R8 y3 after reset", y3, '0);
  endtask

  task automatic t_infinity();
    @(negedge clk);
    drive_ops(19'h1A2B3, '0, 19'h0F0F0, 19'h12345, 19'h54321, 19'h7ABCD);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (LAT - 2) @(negedge clk);
    chk(done == 1'b0, "R4 R3 done low before latency on Z1 zero", M'(done), '0);
    @(negedge clk);
    chk(done == 1'b1, "R4 done at latency on Z1 zero", M'(done), M'(1));
    chk(err == 1'b1, "R4 err raised on Z1 zero", M'(err), M'(1));
    chk(x3 == '0, "R4 x3 zero on error", x3, '0);
    chk(y3 == '0, "R4 y3 zero on error", y3, '0);
  endtask

  task automatic t_hold();
    logic [M-1:0] hx, hy;
    logic he;
    hx = x3; hy = y3; he = err;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (i == 10) drive_ops(nextval(), nextval(), nextval(), nextval(), nextval(), nextval());
    end
    chk(done == 1'b1, "R7 done held", M'(done), M'(1));
    chk(x3 == hx && y3 == hy && err == he, "R7 results held", x3, hx);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    t_reset();
    @(negedge clk);
    rst_n = 1'b1;
    t_reset();

    t_convert(19'h1A2B3, 19'h0C0DE, 19'h2F00D, 19'h31337, 19'h4BEEF, 19'h55AA5, 1'b0);
    t_hold();
    t_convert(19'h7FFFF, 19'h00001, 19'h00002, 19'h00001, 19'h00001, 19'h00000, 1'b0);
    t_convert(19'h13579, 19'h2468A, 19'h0ACE1, 19'h3BDF0, 19'h6C6C6, 19'h12121, 1'b1);
    t_infinity();
    t_hold();
    t_convert(19'h40000, 19'h40000, 19'h00100, 19'h7FFFF, 19'h40001, 19'h7FFFF, 1'b0);
    for (int n = 0; n < 4; n++) begin
      logic [M-1:0] c1, c2, ap;
      c1 = nextval(); c2 = nextval(); ap = nextval();
      if (c1 == '0) c1 = 19'h1;
      if (c2 == '0) c2 = 19'h3;
      if (ap == '0) ap = 19'h5;
      t_convert(nextval(), c1, nextval(), c2, ap, nextval(), n[0]);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule